// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM. It accepts a command on every enabled clock edge. A command is a read, a write or a deselect, and reads and writes may follow each other in any mix with no idle cycle between them. The trick that removes turnaround gaps is symmetry: write data lags its address by the same two enabled edges that read data does. At any moment the shared data bus therefore carries exactly one transfer, driven either by the memory or by the controller.

The data bus is split into an input port, an output port and a drive enable. An internal two-bit burst counter lets the controller stream four-word groups with a single address. The counter steps in wrapping linear order or in XOR order, chosen when the burst is loaded. A clock-enable input freezes the whole block. An asynchronous output enable only gates the drive.

Top module: `zt_sram`

## Requirements
- R1: After reset the pipeline holds no command, `d_oe` is 0 and `d_out` is 0.
- R2: A read sampled at enabled edge k puts the stored word on `d_out` at edge k+1, and the word stays there for sampling at edge k+2. `d_oe` is 1 during that cycle when `oe_n` is 0.
- R3: For a write sampled at enabled edge k, the memory takes `d_in` at enabled edge k+2 and stores it at the write's address.
- R4: A write changes only the 9-bit lanes whose `bsel` bit is 1. Bit i of `bsel` covers `d_in[9*i+8:9*i]`.
- R5: A command is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 all hold. A deselected load changes no memory word and drives no data.
- R6: A read that directly follows a write to the same address returns the new lanes merged with the old stored lanes.
- R7: While `cke` is 0, no register changes: `d_out`, the drive state, the memory, the pipeline and the burst state all hold.
- R8: `oe_n`=1 forces `d_oe` to 0 and has no other effect. The read data still appears on `d_out`.
- R9: `d_oe` is 0 in every cycle in which the bus carries write data, i.e. the cycle before a write's data edge.
- R10: With `adv`=1 after a load made with `ilv`=0, the low two address bits become start+count mod 4, where the count is the number of advances.
- R11: After a load made with `ilv`=1, each advance uses the low two address bits start XOR count.
- R12: During `adv`=1, `addr`, `wen` and the chip selects are ignored. The command type and the selection come from the last load, and `bsel` is taken fresh every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| cke | input | 1 | Clock enable; 0 stalls everything |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new command |
| wen | input | 1 | 1 = write, 0 = read (on a load) |
| bsel | input | LANES | Per-lane write selects, active high |
| addr | input | ADDR_W | Word address (on a load) |
| ilv | input | 1 | Burst order on a load: 0 linear, 1 XOR |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data from the bus |
| d_out | output | LANES*LANE_W | Registered read data |
| d_oe | output | 1 | Bus drive enable |

## Verification
The case that is hardest to reach from the ports is a read that lands on the same address as the write one cycle ahead of it. The write's data is sampled at the very edge at which the read fetches memory, so the merge path is the only thing that can return the right value. The bench reaches this case in a directed phase that alternates write and read to one address under every lane mask. It reaches it again in a long random phase that confines addresses to eight words, so that collisions are frequent while stalls, bursts and deselects are interleaved. Burst order is swept over every start offset in both orders, with address, write enable and chip selects scrambled during the advances.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    adv,
  input  logic                    wen,
  input  logic [LANES-1:0]        bsel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ilv,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic              b_act, b_wr, b_ilv;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  logic              s1_vld, s1_wr, s2_vld, s2_wr, drv;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_msk, s2_msk;

  wire              sel     = ~cs0_n & cs1 & ~cs2_n;
  wire [1:0]        nxt_cnt = b_cnt + 2'd1;
  wire [1:0]        lo      = b_ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  wire              c_vld   = adv ? b_act : sel;
  wire              c_wr    = adv ? b_wr : wen;
  wire [ADDR_W-1:0] c_addr  = adv ? {b_base[ADDR_W-1:2], lo} : addr;
  wire              fwd     = s2_vld & s2_wr & (s2_addr == s1_addr);

  logic [DW-1:0] rd_mrg, wr_new;
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_mrg[l*LANE_W +: LANE_W] = (fwd && s2_msk[l]) ? d_in[l*LANE_W +: LANE_W]
                                                      : mem[s1_addr][l*LANE_W +: LANE_W];
      wr_new[l*LANE_W +: LANE_W] = s2_msk[l] ? d_in[l*LANE_W +: LANE_W]
                                             : mem[s2_addr][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_ilv  <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (cke) begin
      if (adv) begin
        b_cnt <= nxt_cnt;
      end else begin
        b_act  <= sel;
        b_wr   <= wen;
        b_ilv  <= ilv;
        b_base <= addr;
        b_cnt  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_msk  <= '0;
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_msk  <= '0;
      drv     <= 1'b0;
      d_out   <= '0;
    end else if (cke) begin
      s1_vld  <= c_vld;
      s1_wr   <= c_wr;
      s1_addr <= c_addr;
      s1_msk  <= bsel;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_msk  <= s1_msk;
      drv     <= s1_vld & ~s1_wr;
      if (s1_vld && !s1_wr) d_out <= rd_mrg;
    end
  end

  always_ff @(posedge clk) begin
    if (cke && s2_vld && s2_wr) mem[s2_addr] <= wr_new;
  end

  assign d_oe = drv & ~oe_n;
endmodule

module zt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          oe_n,
  input logic          d_oe,
  input logic [DW-1:0] d_out,
  input logic          drv,
  input logic          s1_vld,
  input logic          s1_wr,
  input logic          s2_vld,
  input logic          s2_wr
);
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) d_oe |-> !(s2_vld && s2_wr)); // R9
  AST_STALL_HOLDS_DOUT: assert property (@(posedge clk) disable iff (!rst_n) !cke |=> $stable(d_out)); // R7
  AST_STALL_HOLDS_PIPE: assert property (@(posedge clk) disable iff (!rst_n) !cke |=> $stable(s2_vld) && $stable(drv)); // R7
  AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !d_oe); // R8
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) cke && s1_vld && !s1_wr |=> drv); // R2
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) cke && !s1_vld |=> !drv); // R5
endmodule

bind zt_sram zt_sram_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .oe_n(oe_n), .d_oe(d_oe), .d_out(d_out),
  .drv(drv), .s1_vld(s1_vld), .s1_wr(s1_wr), .s2_vld(s2_vld), .s2_wr(s2_wr)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 0, rst_n = 0, cke = 0, cs0_n = 1, cs1 = 0, cs2_n = 1;
  logic adv = 0, wen = 0, ilv = 0, oe_n = 0;
  logic [NL-1:0] bsel = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_oe;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv(adv), .wen(wen), .bsel(bsel), .addr(addr), .ilv(ilv), .oe_n(oe_n),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, n = 0, desel_k = 0;
  logic [DW-1:0] refm [1<<AW];
  logic          h_vld [4], h_wr [4];
  logic [AW-1:0] h_addr [4];
  logic [NL-1:0] h_msk [4];
  logic [DW-1:0] h_dat [4];
  logic          bb_act = 0, bb_wr = 0, bb_ilv = 0;
  logic [AW-1:0] bb_base = '0;
  logic [1:0]    bb_cnt = '0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [63:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * (a + 1) ^ (64'(salt) << 17) ^ 64'(salt);
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] rnd();
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    return v[DW-1:0];
  endfunction

  task automatic op(input bit ce, input bit ad, input bit we, input logic [AW-1:0] a,
                    input logic [NL-1:0] m, input bit s, input bit iv, input bit oen,
                    input logic [DW-1:0] wd, input string tag);
    int i1, i2, ic;
    bit rd_exp;
    logic [DW-1:0] e, pd;
    logic po;
    logic [1:0] nc, lo;
    @(negedge clk);
    i1 = (n + 3) & 3;
    i2 = (n + 2) & 3;
    ic = n & 3;
    cke = ce; adv = ad; wen = we; addr = a; bsel = m; ilv = iv; oe_n = oen;
    if (s) begin
      cs0_n = 0; cs1 = 1; cs2_n = 0;
    end else begin
      desel_k = (desel_k + 1) % 3;
      cs0_n = (desel_k == 0); cs1 = (desel_k != 1); cs2_n = (desel_k == 2);
    end
    d_in = (n >= 2 && h_vld[i2] && h_wr[i2]) ? h_dat[i2] : rnd();
    if (!ce) begin
      #1;
      pd = d_out; po = d_oe;
      @(posedge clk); #2;
      chk(d_out == pd, "R7 d_out held", d_out, pd);
      chk(d_oe == po, "R7 drive held", {35'b0, d_oe}, {35'b0, po});
      return;
    end
    if (ad) begin
      nc = bb_cnt + 2'd1;
      lo = bb_ilv ? (bb_base[1:0] ^ nc) : (bb_base[1:0] + nc);
      bb_cnt = nc;
      h_vld[ic] = bb_act; h_wr[ic] = bb_wr; h_addr[ic] = {bb_base[AW-1:2], lo};
    end else begin
      bb_act = s; bb_wr = we; bb_ilv = iv; bb_base = a; bb_cnt = 0;
      h_vld[ic] = s; h_wr[ic] = we; h_addr[ic] = a;
    end
    h_msk[ic] = m; h_dat[ic] = wd;
    if (n >= 2 && h_vld[i2] && h_wr[i2])
      for (int l = 0; l < NL; l++)
        if (h_msk[i2][l]) refm[h_addr[i2]][l*LW +: LW] = h_dat[i2][l*LW +: LW];
    rd_exp = (n >= 1) && h_vld[i1] && !h_wr[i1];
    e = rd_exp ? refm[h_addr[i1]] : '0;
    @(posedge clk); #2;
    if (rd_exp) begin
      chk(d_out == e, tag, d_out, e);
      chk(d_oe == !oen, "R8 drive follows oe_n", {35'b0, d_oe}, {35'b0, !oen});
    end else if (n >= 1 && h_vld[i1] && h_wr[i1]) begin
      chk(d_oe == 0, "R9 no drive on write data cycle", {35'b0, d_oe}, '0);
    end else begin
      chk(d_oe == 0, "R5 no drive when idle", {35'b0, d_oe}, '0);
    end
    n++;
  endtask

  task automatic flush();
    op(1, 0, 0, '0, '0, 0, 0, 0, '0, "R5 flush");
    op(1, 0, 0, '0, '0, 0, 0, 0, '0, "R5 flush");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) h_vld[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(d_oe == 0, "R1 no drive after reset", {35'b0, d_oe}, '0);
    chk(d_out == '0, "R1 d_out after reset", d_out, '0);
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < (1 << AW); a++) op(1, 0, 1, a[AW-1:0], '1, 1, 0, 0, pat(a, 1), "R3 fill");
    for (int a = 0; a < (1 << AW); a++) op(1, 0, 0, a[AW-1:0], '0, 1, 0, 0, '0, "R2 R3 readback");
    flush();

    for (int m = 0; m < 16; m++) op(1, 0, 1, m[AW-1:0], m[NL-1:0], 1, 0, 0, pat(m, 7), "R4 lane write");
    for (int m = 0; m < 16; m++) op(1, 0, 0, m[AW-1:0], '0, 1, 0, 0, '0, "R4 lane readback");
    flush();

    for (int m = 0; m < 16; m++) begin
      op(1, 0, 1, 6'd20, m[NL-1:0], 1, 0, 0, pat(m, 33), "R6 write");
      op(1, 0, 0, 6'd20, '0, 1, 0, 0, '0, "R6 read after write merge");
    end
    flush();

    op(1, 0, 1, 6'd5, '1, 0, 0, 0, pat(5, 99), "R5 deselected write");
    op(1, 0, 0, 6'd5, '0, 0, 0, 0, '0, "R5 deselected read");
    op(1, 0, 0, 6'd5, '0, 1, 0, 0, '0, "R5 word unchanged");
    op(1, 0, 0, 6'd5, '0, 1, 0, 1, '0, "R8 read with oe_n high");
    flush();

    for (int md = 0; md < 2; md++)
      for (int st = 0; st < 4; st++) begin
        op(1, 0, 1, 6'(32 + 4*st + st), '1, 1, md[0], 0, pat(st, 200 + md), md ? "R11 burst" : "R10 burst");
        for (int k = 0; k < 3; k++)
          op(1, 1, 0, 6'(k * 13), '1, 0, !md[0], 0, pat(k, 300 + 8*md + st), "R12 advance ignores addr/we/cs");
        op(1, 0, 0, 6'(32 + 4*st + st), '0, 1, md[0], 0, '0, md ? "R11 burst read" : "R10 burst read");
        for (int k = 0; k < 3; k++)
          op(1, 1, 1, 6'(k * 7), '0, 0, !md[0], 0, '0, md ? "R11 burst read" : "R10 burst read");
      end
    flush();

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      op(r >= 18, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
         6'($urandom_range(0, 7)), NL'($urandom()), $urandom_range(0, 9) != 0,
         $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0, rnd(), "R6 R7 random mix");
    end
    op(0, 0, 0, '0, '0, 0, 0, 0, '0, "R7 stall");
    flush();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule